// File: doc/BRIEF.md
# Debug-board interrupt expander

This block gathers up to sixteen active-high level interrupt requests from the peripherals of a debug board. The sources include a network controller, two serial ports and two push buttons. Each request is synchronised to the block clock and latched into a status word. The block drives one active-low, level-sensitive request line to the host processor. That line is low while any latched bit is also enabled in the mask word. The two button inputs also pass through a debounce filter. It accepts a new level only after the level has held for a set number of cycles.

A plain 16-bit register bus gives the host access to the status, mask and clear words. The same bus reaches an LED output word, a readable copy of the board switches, three fixed identification words, a version word and two general-purpose read/write words. The host detects the board by reading the identification words.

To clear a status bit, the host writes a 1 to that bit of the clear word. The bit stays forced to zero until the host writes the clear word back to 0.

Top module: `board_irq_expander`

## Requirements
- R1: After reset, `irq_n_o` is 1, the status word (offset 0x10) reads 0x0000, the mask word (offset 0x38) reads 0xFFFF, and the LED word (0x00), the clear word (0x20), the control word (0x60) and the identity word (0x68) all read 0x0000.
- R2: The word at 0x40 reads 0xAAAA, the word at 0x48 reads 0x5555 and the word at 0x58 reads 0xCAFE. The word at 0x50 reads the VERSION parameter (default 0x0102). Writes to these four offsets change nothing.
- R3: A source that is not a button (every bit except bits 3 and 4) sets its status bit once it has held high through the two-flop synchroniser. The bit stays set after the source returns low.
- R4: `irq_n_o` is 0 exactly when some status bit is 1 and the mask bit in the same position is 0. A mask bit of 1 disables that source.
- R5: While a bit of the clear word holds 1, that status bit is 0, even if its source is held active. When the clear word returns to 0, a source that is still active sets the bit again.
- R6: Sources 3 and 4 (the buttons) reach the status word only after their synchronised level has held for DB_CYCLES consecutive cycles (default 8). A pulse of 3 cycles leaves the status bit at 0.
- R7: The word written at offset 0x00 appears on `led_o` and reads back. Offset 0x08 reads `sw_i` after a two-flop synchroniser.
- R8: The words at 0x60 and 0x68 hold whatever was last written to them and have no other effect.
- R9: Writes to the status word (0x10) change nothing. Reads of any offset outside the mapped set return 0x0000.
- R10: When the last enabled pending bit is cleared, `irq_n_o` returns to 1 once the clear takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Byte offset of the register accessed |
| wr_en_i | input | 1 | Write strobe; the write takes effect at the rising clock edge |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| src_i | input | SRC_N | Active-high interrupt request levels |
| sw_i | input | 16 | Board switch levels |
| led_o | output | 16 | LED drive word |
| irq_n_o | output | 1 | Aggregated interrupt to the host, active low |

## Verification
A source can be active in the same cycle that its bit of the clear word is 1. In that case the clear wins, and the request must come back once the clear word is released. The bench provokes this by holding a source high, writing the clear word, and reading the status over several cycles. It expects the bit to be 0 throughout the hold. Once the clear word returns to zero, it expects the bit to be 1 again within two cycles and the request line to go low.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 8;

  typedef logic [ADDR_W-1:0] reg_addr_t;
  typedef logic [REG_W-1:0]  reg_word_t;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_LED, SEL_SW, SEL_STAT, SEL_CLR, SEL_MASK,
    SEL_ID1, SEL_ID2, SEL_VER, SEL_ID3, SEL_CTRL, SEL_IDENT
  } reg_sel_e;

  localparam reg_word_t ID1_WORD = 16'hAAAA;
  localparam reg_word_t ID2_WORD = 16'h5555;
  localparam reg_word_t ID3_WORD = 16'hCAFE;

  function automatic reg_sel_e decode_offset(reg_addr_t a);
    case (a)
      8'h00:   return SEL_LED;
      8'h08:   return SEL_SW;
      8'h10:   return SEL_STAT;
      8'h20:   return SEL_CLR;
      8'h38:   return SEL_MASK;
      8'h40:   return SEL_ID1;
      8'h48:   return SEL_ID2;
      8'h50:   return SEL_VER;
      8'h58:   return SEL_ID3;
      8'h60:   return SEL_CTRL;
      8'h68:   return SEL_IDENT;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic reg_word_t pending_bits(reg_word_t st, reg_word_t mk);
    return st & ~mk;
  endfunction

  function automatic reg_word_t status_update(reg_word_t st, reg_word_t req,
                                              reg_word_t clr);
    return (st | req) & ~clr;
  endfunction
endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/irqx_debounce.sv
module irqx_debounce #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          level_q;
  logic          differs;
  logic          accept;

  assign differs = d_i != level_q;
  assign accept  = differs && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (accept) begin
      cnt_q   <= '0;
      level_q <= d_i;
    end else if (differs) begin
      cnt_q   <= cnt_q + 1'b1;
    end else begin
      cnt_q   <= '0;
    end
  end

  assign q_o = level_q;

  AST_DB_FLIP_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(cnt_q) == LAST)); // R6
endmodule

// File: rtl/irqx_input_cond.sv
module irqx_input_cond
  import irqx_pkg::*;
#(
  parameter int        SRC_N     = 16,
  parameter reg_word_t BTN_SEL   = 16'h0018,
  parameter int        DB_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_i,
  output reg_word_t        req_o
);
  logic [SRC_N-1:0] synced;

  irqx_sync #(.W(SRC_N)) u_src_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_i),
    .q_o   (synced)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i >= SRC_N) begin : g_unused
      assign req_o[i] = 1'b0;
    end else if (BTN_SEL[i]) begin : g_button
      irqx_debounce #(.CYC(DB_CYCLES)) u_db (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (synced[i]),
        .q_o   (req_o[i])
      );
    end else begin : g_plain
      assign req_o[i] = synced[i];
    end
  end
endmodule

// File: rtl/irqx_status.sv
module irqx_status
  import irqx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  reg_word_t req_i,
  input  reg_word_t clr_i,
  input  reg_word_t mask_i,
  output reg_word_t status_o,
  output logic      irq_n_o
);
  reg_word_t status_q;
  reg_word_t pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_update(status_q, req_i, clr_i);
  end

  assign pend     = pending_bits(status_q, mask_i);
  assign irq_n_o  = ~|pend;
  assign status_o = status_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((status_q & $past(clr_i)) == '0)); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~status_q & ~$past(clr_i)) == '0)); // R3
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> (status_q != '0)); // R4
  AST_IRQ_IDLE_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> irq_n_o); // R1
endmodule

// File: rtl/irqx_regfile.sv
module irqx_regfile
  import irqx_pkg::*;
#(
  parameter reg_word_t VERSION = 16'h0102
) (
  input  logic      clk,
  input  logic      rst_n,
  input  reg_addr_t addr_i,
  input  logic      wr_en_i,
  input  reg_word_t wdata_i,
  input  reg_word_t status_i,
  input  reg_word_t sw_i,
  output reg_word_t rdata_o,
  output reg_word_t led_o,
  output reg_word_t clr_o,
  output reg_word_t mask_o
);
  reg_sel_e  sel;
  reg_word_t led_q, clr_q, mask_q, ctrl_q, ident_q;

  assign sel = decode_offset(addr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q   <= '0;
      clr_q   <= '0;
      mask_q  <= '1;
      ctrl_q  <= '0;
      ident_q <= '0;
    end else if (wr_en_i) begin
      case (sel)
        SEL_LED:   led_q   <= wdata_i;
        SEL_CLR:   clr_q   <= wdata_i;
        SEL_MASK:  mask_q  <= wdata_i;
        SEL_CTRL:  ctrl_q  <= wdata_i;
        SEL_IDENT: ident_q <= wdata_i;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_LED:   rdata_o = led_q;
      SEL_SW:    rdata_o = sw_i;
      SEL_STAT:  rdata_o = status_i;
      SEL_CLR:   rdata_o = clr_q;
      SEL_MASK:  rdata_o = mask_q;
      SEL_ID1:   rdata_o = ID1_WORD;
      SEL_ID2:   rdata_o = ID2_WORD;
      SEL_VER:   rdata_o = VERSION;
      SEL_ID3:   rdata_o = ID3_WORD;
      SEL_CTRL:  rdata_o = ctrl_q;
      SEL_IDENT: rdata_o = ident_q;
      default:   rdata_o = '0;
    endcase
  end

  assign led_o  = led_q;
  assign clr_o  = clr_q;
  assign mask_o = mask_q;

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == 8'h38) |=> $stable(mask_q)); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (rdata_o == '0)); // R9
endmodule

// File: rtl/board_irq_expander.sv
module board_irq_expander
  import irqx_pkg::*;
#(
  parameter int        SRC_N     = 16,
  parameter reg_word_t BTN_SEL   = 16'h0018,
  parameter int        DB_CYCLES = 8,
  parameter reg_word_t VERSION   = 16'h0102
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       addr_i,
  input  logic             wr_en_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o,
  input  logic [SRC_N-1:0] src_i,
  input  logic [15:0]      sw_i,
  output logic [15:0]      led_o,
  output logic             irq_n_o
);
  reg_word_t req, clr, mask, status, sw_sync;

  irqx_input_cond #(
    .SRC_N     (SRC_N),
    .BTN_SEL   (BTN_SEL),
    .DB_CYCLES (DB_CYCLES)
  ) u_cond (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .req_o (req)
  );

  irqx_sync #(.W(REG_W)) u_sw_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sw_i),
    .q_o   (sw_sync)
  );

  irqx_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req),
    .clr_i    (clr),
    .mask_i   (mask),
    .status_o (status),
    .irq_n_o  (irq_n_o)
  );

  irqx_regfile #(.VERSION(VERSION)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wdata_i  (wdata_i),
    .status_i (status),
    .sw_i     (sw_sync),
    .rdata_o  (rdata_o),
    .led_o    (led_o),
    .clr_o    (clr),
    .mask_o   (mask)
  );
endmodule

// File: tb/test_board_irq_expander.sv
`timescale 1ns/100ps
module test_board_irq_expander;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] src = '0;
  logic [15:0] sw = '0;
  logic [15:0] led;
  logic        irq_n;
  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  board_irq_expander i_board_irq_expander (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .sw_i(sw),
    .led_o(led), .irq_n_o(irq_n)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic bit mapped(logic [7:0] a);
    case (a)
      8'h00, 8'h08, 8'h10, 8'h20, 8'h38, 8'h40, 8'h48,
      8'h50, 8'h58, 8'h60, 8'h68: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] reset_value(logic [7:0] a);
    case (a)
      8'h38: return 16'hFFFF;
      8'h40: return 16'hAAAA;
      8'h48: return 16'h5555;
      8'h50: return 16'h0102;
      8'h58: return 16'hCAFE;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic exp_irq(logic [15:0] st, logic [15:0] mk);
    return ((st & ~mk) == 16'h0) ? 1'b1 : 1'b0;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [15:0] mk;
    idle(3);
    #1 check("R1 irq_n in reset", {15'h0, irq_n}, 16'h1);
    rst_n = 1'b1;
    idle(2);
    check("R1 irq_n after reset", {15'h0, irq_n}, 16'h1);
    check("R1 led after reset", led, 16'h0);

    // R1 R2 R9: full offset sweep at reset state
    for (int a = 0; a < 128; a++) begin
      rd(8'(a), d);
      if (mapped(8'(a))) check($sformatf("R1 R2 reset read %h", a), d, reset_value(8'(a)));
      else check($sformatf("R9 unmapped read %h", a), d, 16'h0);
    end

    // R2: identification writes ignored; R9: status write ignored
    wr(8'h40, 16'h1234); wr(8'h48, 16'h1234); wr(8'h50, 16'h1234); wr(8'h58, 16'h1234);
    rd(8'h40, d); check("R2 id1 after write", d, 16'hAAAA);
    rd(8'h48, d); check("R2 id2 after write", d, 16'h5555);
    rd(8'h50, d); check("R2 version after write", d, 16'h0102);
    rd(8'h58, d); check("R2 id3 after write", d, 16'hCAFE);
    wr(8'h10, 16'hFFFF);
    rd(8'h10, d); check("R9 status write ignored", d, 16'h0);
    wr(8'h14, 16'hFFFF);
    rd(8'h14, d); check("R9 unmapped write", d, 16'h0);

    // R7: LED and switches
    wr(8'h00, 16'h5AC3);
    check("R7 led_o", led, 16'h5AC3);
    rd(8'h00, d); check("R7 led readback", d, 16'h5AC3);
    sw = 16'hB00F; idle(3);
    rd(8'h08, d); check("R7 switch read", d, 16'hB00F);

    // R8: placeholders
    wr(8'h60, 16'h0F0F); wr(8'h68, 16'hBEEF);
    rd(8'h60, d); check("R8 control word", d, 16'h0F0F);
    rd(8'h68, d); check("R8 identity word", d, 16'hBEEF);
    check("R8 no irq effect", {15'h0, irq_n}, 16'h1);

    // R3 R4 R5 R10: per-bit sweep over plain sources
    wr(8'h38, 16'h0000);
    for (int i = 0; i < 16; i++) begin
      if (i == 3 || i == 4) continue;
      src = 16'(1) << i; idle(4);
      rd(8'h10, d); check($sformatf("R3 set bit %0d", i), d, 16'(1) << i);
      check($sformatf("R4 irq low bit %0d", i), {15'h0, irq_n}, 16'h0);
      src = '0; idle(4);
      rd(8'h10, d); check($sformatf("R3 sticky bit %0d", i), d, 16'(1) << i);
      wr(8'h38, 16'(1) << i);
      check($sformatf("R4 masked bit %0d", i), {15'h0, irq_n}, 16'h1);
      wr(8'h38, 16'h0000);
      check($sformatf("R4 unmasked bit %0d", i), {15'h0, irq_n}, 16'h0);
      wr(8'h20, 16'(1) << i); idle(1);
      rd(8'h10, d); check($sformatf("R5 cleared bit %0d", i), d, 16'h0);
      check($sformatf("R10 irq released bit %0d", i), {15'h0, irq_n}, 16'h1);
      wr(8'h20, 16'h0000);
    end

    // R5: clear held against an active source, then release
    src = 16'h0001; idle(4);
    wr(8'h20, 16'h0001); idle(1);
    for (int k = 0; k < 4; k++) begin
      rd(8'h10, d); check("R5 clear wins while held", d, 16'h0);
    end
    check("R5 irq high while held", {15'h0, irq_n}, 16'h1);
    wr(8'h20, 16'h0000); idle(1);
    rd(8'h10, d); check("R5 relatch after release", d, 16'h0001);
    check("R5 irq low after release", {15'h0, irq_n}, 16'h0);
    src = '0; idle(3);
    wr(8'h20, 16'hFFFF); wr(8'h20, 16'h0000);

    // R6: buttons
    src = 16'h0008; idle(3); src = '0; idle(20);
    rd(8'h10, d); check("R6 short pulse bit 3", d, 16'h0);
    src = 16'h0010; idle(3); src = '0; idle(20);
    rd(8'h10, d); check("R6 short pulse bit 4", d, 16'h0);
    src = 16'h0018; idle(20); src = '0; idle(20);
    rd(8'h10, d); check("R6 held buttons", d, 16'h0018);
    wr(8'h20, 16'hFFFF); wr(8'h20, 16'h0000); idle(1);
    rd(8'h10, d); check("R6 buttons cleared", d, 16'h0);

    // R4: mask sweep over a latched pattern
    src = 16'h0027; idle(4); src = '0; idle(3);
    for (int m = 0; m < 64; m++) begin
      mk = 16'hFFC0 | 16'(m);
      wr(8'h38, mk);
      check($sformatf("R4 mask sweep %h", mk), {15'h0, irq_n}, {15'h0, exp_irq(16'h0027, mk)});
    end
    wr(8'h38, 16'h0000);
    wr(8'h20, 16'h0007); idle(1);
    check("R10 one bit still pending", {15'h0, irq_n}, 16'h0);
    wr(8'h20, 16'h0027); idle(1);
    check("R10 last bit cleared", {15'h0, irq_n}, 16'h1);
    wr(8'h20, 16'h0000);

    summary();
    $finish;
  end
endmodule